// File: doc/BRIEF.md
# Channel Interrupt Request Gating

This block sits in each channel of a serial controller. It takes four condition flags from the receive, transmit and modem-status logic, masks them with a 4-bit interrupt-enable register, and merges them into one interrupt request. It also produces a 3-bit source code that a host read path can return. The code names the most urgent enabled condition that is pending.

One bit of the modem-control register chooses what the channel's output pins do. When the bit is set, the interrupt pin is driven actively and the general-purpose output sits low. When the bit is clear, the interrupt pin's output enable drops, so the pad floats, and the general-purpose output sits high. One pin pair therefore serves either as an interrupt line or as a user output, never both at once.

The transmit-empty condition arrives as a one-cycle event and is held in a latch here. Writing the transmit register clears it. Reading the source code while that code reports transmit-empty also clears it.

Top module: `uart_irq_gate`

## Requirements
- R1: While reset is low, and after it is released until the first register write, the outputs are irq_oe_o=0, irq_o=0, gpo_o=1 and iid_o=3'b001. This holds whatever the condition inputs are, because the enable register resets to 0.
- R2: A cycle with ctl_we_i=1 and reg_wdata_i[3]=1 makes irq_oe_o=1 and gpo_o=0 from the next clock edge on.
- R3: A cycle with ctl_we_i=1 and reg_wdata_i[3]=0 makes irq_oe_o=0, gpo_o=1 and irq_o=0 from the next clock edge on, whatever is pending.
- R4: A cycle with ier_we_i=1 loads the enable register from reg_wdata_i[3:0] at the clock edge. The bit map is: bit0 receive data available, bit1 transmit empty, bit2 receiver error, bit3 modem status change. irq_o is 1 only when the drive bit is 1 and at least one enabled condition is pending. The condition inputs act on irq_o in the same cycle.
- R5: iid_o reports the highest-priority enabled pending source. The order and codes are: receiver error 3'b110, then receive data 3'b100, then transmit empty 3'b010, then modem change 3'b000.
- R6: iid_o is 3'b001 when no enabled source is pending. iid_o does not depend on the drive bit.
- R7: A cycle with tx_empty_set_i=1 makes the transmit-empty condition pending from the next edge on. It stays pending until it is cleared.
- R8: The transmit-empty condition is cleared at the edge after a cycle with thr_wr_i=1. It is also cleared at the edge after a cycle with iid_rd_i=1 while iid_o=3'b010. A read while iid_o shows any other code leaves it pending.
- R9: When tx_empty_set_i=1 in the same cycle as a clear, the condition is pending afterwards.
- R10: Bits 7:4 of reg_wdata_i in an enable write have no effect. Only bit 3 of a control write has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wdata_i | input | 8 | Register write data |
| ier_we_i | input | 1 | Interrupt-enable register write strobe |
| ctl_we_i | input | 1 | Modem-control register write strobe (only bit 3 used) |
| rx_err_i | input | 1 | Receiver error condition |
| rx_avail_i | input | 1 | Receive data available condition |
| tx_empty_set_i | input | 1 | Transmit holding register became empty (event) |
| modem_chg_i | input | 1 | Modem status change condition |
| thr_wr_i | input | 1 | Transmit register write (clears transmit-empty) |
| iid_rd_i | input | 1 | Source-code register read |
| irq_o | output | 1 | Interrupt request value |
| irq_oe_o | output | 1 | Interrupt pin output enable |
| gpo_o | output | 1 | General-purpose output |
| iid_o | output | 3 | Pending source code |

## Verification
Suppose the enable register or the drive bit holds a wrong value. The first condition that the bad bit masks wrongly shows up on irq_o and iid_o in that same cycle. A wrong drive bit shows up on irq_oe_o and gpo_o at once. A transmit-empty latch that sets or clears wrongly shows up one edge after the event, as a wrong iid_o or irq_o. It can only be seen while no higher-priority source is pending. For that reason the bench also drives that latch with the other conditions low. A bench model predicts every output every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int CODE_W  = 3;

  // index = priority rank, 0 highest
  typedef enum logic [1:0] {
    SRC_RXERR = 2'd0,
    SRC_RXAVL = 2'd1,
    SRC_THRE  = 2'd2,
    SRC_MODEM = 2'd3
  } src_e;

  localparam logic [CODE_W-1:0] ID_NONE = 3'b001;

  function automatic logic [CODE_W-1:0] src_code(input int rank);
    case (rank)
      0:       return 3'b110;
      1:       return 3'b100;
      2:       return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  // position of each source in the enable register
  function automatic int ier_pos(input int rank);
    case (rank)
      0:       return 2;
      1:       return 0;
      2:       return 1;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_cfg.sv
module uart_irq_cfg #(
  parameter int DATA_W  = 8,
  parameter int IER_W   = 4,
  parameter int DRV_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ier_we_i,
  input  logic              ctl_we_i,
  output logic [IER_W-1:0]  ier_o,
  output logic              drv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_o <= '0;
      drv_o <= 1'b0;
    end else begin
      if (ier_we_i) ier_o <= wdata_i[IER_W-1:0];
      if (ctl_we_i) drv_o <= wdata_i[DRV_BIT];
    end
  end

  AST_IER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_we_i |=> $stable(ier_o)); // R10
  AST_DRV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(drv_o)); // R2
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_clr_i,
  input  logic rd_i,
  input  logic shown_i,
  output logic pend_o
);
  logic clr;
  assign clr = wr_clr_i | (rd_i & shown_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;   // new event wins
    else if (clr)    pend_o <= 1'b0;
  end

  AST_THRE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o); // R9
  AST_THRE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && !set_i) |=> !pend_o); // R8
  AST_THRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !wr_clr_i && !rd_i) |=> $stable(pend_o)); // R7
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] req_i,  // by rank, bit 0 highest
  input  logic [NUM_SRC-1:0] en_i,
  output logic [CODE_W-1:0]  id_o,
  output logic               any_o
);
  logic [NUM_SRC-1:0] act;
  logic [NUM_SRC:0]   free;          // no higher rank active
  logic [CODE_W-1:0]  part [NUM_SRC+1];

  assign act     = req_i & en_i;
  assign free[0] = 1'b1;
  assign part[0] = ID_NONE;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
    assign free[g+1] = free[g] & ~act[g];
    assign part[g+1] = (free[g] & act[g]) ? src_code(g) : part[g];
  end

  assign id_o  = part[NUM_SRC];
  assign any_o = ~free[NUM_SRC];

  AST_TOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act[0] |-> id_o == 3'b110); // R5
  AST_NONE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == '0) |-> id_o == ID_NONE); // R6
endmodule

// File: rtl/uart_irq_gate.sv
module uart_irq_gate
  import uart_irq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IER_W   = 4,
  parameter int DRV_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              ier_we_i,
  input  logic              ctl_we_i,
  input  logic              rx_err_i,
  input  logic              rx_avail_i,
  input  logic              tx_empty_set_i,
  input  logic              modem_chg_i,
  input  logic              thr_wr_i,
  input  logic              iid_rd_i,
  output logic              irq_o,
  output logic              irq_oe_o,
  output logic              gpo_o,
  output logic [CODE_W-1:0] iid_o
);
  logic [IER_W-1:0]   ier;
  logic               drv;
  logic               thre_pend;
  logic               any;
  logic [NUM_SRC-1:0] req, en;

  uart_irq_cfg #(.DATA_W(DATA_W), .IER_W(IER_W), .DRV_BIT(DRV_BIT)) u_cfg (
    .clk_i, .rst_ni, .wdata_i(reg_wdata_i), .ier_we_i, .ctl_we_i,
    .ier_o(ier), .drv_o(drv)
  );

  uart_irq_thre u_thre (
    .clk_i, .rst_ni, .set_i(tx_empty_set_i), .wr_clr_i(thr_wr_i),
    .rd_i(iid_rd_i), .shown_i(iid_o == src_code(int'(SRC_THRE))),
    .pend_o(thre_pend)
  );

  assign req[SRC_RXERR] = rx_err_i;
  assign req[SRC_RXAVL] = rx_avail_i;
  assign req[SRC_THRE]  = thre_pend;
  assign req[SRC_MODEM] = modem_chg_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_en
    assign en[g] = ier[ier_pos(g)];
  end

  uart_irq_prio u_prio (
    .clk_i, .rst_ni, .req_i(req), .en_i(en), .id_o(iid_o), .any_o(any)
  );

  assign irq_oe_o = drv;
  assign gpo_o    = ~drv;
  assign irq_o    = drv & any;

  AST_DRV_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (irq_oe_o == $past(reg_wdata_i[DRV_BIT])) &&
                 (gpo_o == !$past(reg_wdata_i[DRV_BIT]))); // R2
  AST_HIZ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_oe_o |-> !irq_o); // R3
  AST_IRQ_IID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o |-> (irq_o == !iid_o[0])); // R4
endmodule

// File: tb/uart_irq_gate_test.sv
module uart_irq_gate_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic       ier_we_i = 0, ctl_we_i = 0, rx_err_i = 0, rx_avail_i = 0;
  logic       tx_empty_set_i = 0, modem_chg_i = 0, thr_wr_i = 0, iid_rd_i = 0;
  logic       irq_o, irq_oe_o, gpo_o;
  logic [2:0] iid_o;

  int total = 0, bad = 0;
  logic [3:0] m_ier = '0;
  logic       m_drv = 0, m_thre = 0;

  uart_irq_gate uut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [2:0] exp_iid(input logic [3:0] ie, input logic th,
                                         input logic re, input logic ra, input logic mc);
    if (re && ie[2]) return 3'b110;
    if (ra && ie[0]) return 3'b100;
    if (th && ie[1]) return 3'b010;
    if (mc && ie[3]) return 3'b000;
    return 3'b001;
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic [2:0] e;
    logic       eirq, nthre;
    #2;
    e    = exp_iid(m_ier, m_thre, rx_err_i, rx_avail_i, modem_chg_i);
    eirq = m_drv && (e != 3'b001);
    chk({tag, (m_drv ? " R2 oe" : " R3 oe")}, {2'b0, irq_oe_o}, {2'b0, m_drv});
    chk({tag, (m_drv ? " R2 gpo" : " R3 gpo")}, {2'b0, gpo_o}, {2'b0, !m_drv});
    chk({tag, " R4 irq"}, {2'b0, irq_o}, {2'b0, eirq});
    chk({tag, (m_drv ? " R5 iid" : " R6 iid")}, iid_o, e);
    nthre = tx_empty_set_i ? 1'b1 :
            (thr_wr_i || (iid_rd_i && e == 3'b010)) ? 1'b0 : m_thre;
    @(posedge clk_i);
    if (ier_we_i) m_ier = reg_wdata_i[3:0];
    if (ctl_we_i) m_drv = reg_wdata_i[3];
    m_thre = nthre;
    #1;
  endtask

  task automatic idle();
    ier_we_i = 0; ctl_we_i = 0; tx_empty_set_i = 0; thr_wr_i = 0; iid_rd_i = 0;
  endtask

  task automatic cond(input logic re, input logic ra, input logic mc);
    rx_err_i = re; rx_avail_i = ra; modem_chg_i = mc;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset with every condition raised
    cond(1, 1, 1); tx_empty_set_i = 1;
    repeat (3) @(posedge clk_i);
    #3;
    chk("R1 oe", {2'b0, irq_oe_o}, 3'b000);
    chk("R1 gpo", {2'b0, gpo_o}, 3'b001);
    chk("R1 irq", {2'b0, irq_o}, 3'b000);
    chk("R1 iid", iid_o, 3'b001);
    @(posedge clk_i); #1;
    rst_ni = 1; idle();
    step("R1");
    // enable all, then drive
    reg_wdata_i = 8'h0F; ier_we_i = 1; step("R4");
    idle(); reg_wdata_i = 8'h08; ctl_we_i = 1; step("R2");
    idle(); step("R5 all");
    cond(0, 1, 1); step("R5 rxa");
    cond(0, 0, 1); step("R5 modem");
    tx_empty_set_i = 1; step("R7 set");
    idle(); step("R7 held");
    cond(1, 0, 0); iid_rd_i = 1; step("R8 read other");
    idle(); cond(0, 0, 0); step("R8 still pending");
    iid_rd_i = 1; step("R8 read thre");
    idle(); step("R8 cleared by read");
    tx_empty_set_i = 1; step("R7");
    idle(); thr_wr_i = 1; step("R8 write");
    idle(); step("R8 cleared by write");
    tx_empty_set_i = 1; thr_wr_i = 1; step("R9");
    idle(); step("R9 set wins");
    // R3/R6: float the pin, code still reported
    cond(0, 1, 0); reg_wdata_i = 8'hF7; ctl_we_i = 1; step("R3");
    idle(); step("R6 hiz");
    // R10: upper bits of enable write ignored
    reg_wdata_i = 8'hF0; ier_we_i = 1; step("R10");
    idle(); cond(1, 1, 1); step("R10 ier zero");
    reg_wdata_i = 8'h08; ctl_we_i = 1; step("R10");
    idle(); step("R10 drive");
    // random mix
    for (int i = 0; i < 600; i++) begin
      rx_err_i       = ($urandom % 4) == 0;
      rx_avail_i     = ($urandom % 3) == 0;
      modem_chg_i    = ($urandom % 3) == 0;
      tx_empty_set_i = ($urandom % 6) == 0;
      thr_wr_i       = ($urandom % 8) == 0;
      iid_rd_i       = ($urandom % 4) == 0;
      ier_we_i       = ($urandom % 10) == 0;
      ctl_we_i       = ($urandom % 12) == 0;
      reg_wdata_i    = 8'($urandom);
      step("rnd");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule